// File: doc/BRIEF.md
# Interrupt Controller Mode-Enable Register

This block is the base/enable register of a processor's local interrupt controller. It holds a global enable bit, an extended-mode enable bit, a bootstrap-processor flag and a page-aligned base address for the controller's register window. Software updates it with whole-register writes. Each write is checked before it is committed. The check covers the allowed moves between the three operating modes and the reserved bits. A write that breaks a rule raises a one-cycle fault pulse and leaves the stored value untouched.

The block drives the stored value, the current mode and a feature-present flag. It also decodes one probe address against the window. In legacy mode the window is claimed at the programmed base. In any other mode an access to that page must float, reading back as all ones. Reset places the register in legacy mode at base 0xFEE00000 with the bootstrap flag set. Writes arrive on a valid/ready port. Ready is held high, so there is never back-pressure and at most one write is accepted per cycle. Each accepted write is judged against the value left by the previous write.

Top module: `lic_base_reg`

## Requirements
- R1: After reset, `reg_o` reads 0xFEE00900 (base 0xFEE00, enable bit 11 set, bootstrap bit 8 set), `mode_o` is legacy, `feature_o` is 1 and `fault_o` is 0.
- R2: `mode_o` is 2'b00 (off) when bit 11 is clear, 2'b01 (legacy) when bit 11 is set and bit 10 is clear, and 2'b10 (extended) when both are set. `feature_o` is 1 exactly when the mode is not off.
- R3: A write with bit 10 set and bit 11 clear faults, whatever the current mode.
- R4: From extended mode, a write that selects legacy mode faults. A write that selects off is accepted.
- R5: From off, a write that selects extended mode faults. A write that selects legacy mode is accepted.
- R6: A write that sets any reserved low bit (bit 0, bits 1 to 7, or bit 9) faults.
- R7: A write that sets any bit at or above the physical-address width `PA_W` (default 36) faults. Bits just below that width are stored as base bits.
- R8: A faulting write pulses `fault_o` for one cycle, in the cycle after the write is accepted, and `reg_o` keeps its earlier value.
- R9: While the mode is not legacy, `win_sel_o` is 0. A probe address inside the page at the stored base then gives `win_float_o` = 1, which means the access reads all ones.
- R10: After the base is relocated (for example to 0xFED40000) in legacy mode, `win_sel_o` is 1 for addresses in the new page and 0 for addresses in the old page.
- R11: From legacy mode, moving to extended mode is accepted, and so is a rewrite that keeps the mode and changes the base or the bootstrap flag.
- R12: `wr_ready` is always 1. On back-to-back writes, each write is checked against the value committed by the write before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write accepted (always 1) |
| wr_data | input | 64 | Full register value to write |
| fault_o | output | 1 | One-cycle pulse for a rejected write |
| reg_o | output | 64 | Stored register value |
| mode_o | output | 2 | Current mode: 00 off, 01 legacy, 10 extended |
| feature_o | output | 1 | Feature-present flag |
| win_addr | input | PA_W | Probe address for the register window |
| win_sel_o | output | 1 | Probe hits the active window |
| win_float_o | output | 1 | Probe hits the page while inactive (reads all ones) |

## Verification
The bench steps through every mode pair. It targets the two forbidden direct moves (extended straight to legacy, off straight to extended) and the invalid encoding with extended set and enable clear. A checker that only looked at the requested mode would accept those writes and change the mode. A register that committed before checking would show the new value in the same cycle as the fault. Reserved-bit writes are sent at bit 0, bit 9, bit `PA_W` and bit `PA_W-1`, which catches a mask that is off by one at either end. A back-to-back pair (legacy to extended, then extended to legacy) exposes a design that judges the second write against stale state. Window probes after relocation and after disabling show whether the decode follows the stored base and the mode.

// File: rtl/lic_pkg.sv
package lic_pkg;
  typedef enum logic [1:0] {
    MODE_OFF    = 2'b00,
    MODE_LEGACY = 2'b01,
    MODE_EXT    = 2'b10
  } lic_mode_e;

  localparam int DATA_W   = 64;
  localparam int BSP_BIT  = 8;
  localparam int EXT_BIT  = 10;
  localparam int EN_BIT   = 11;
  localparam int BASE_LSB = 12;

  function automatic lic_mode_e mode_of(input logic en, input logic ext);
    if (!en)     return MODE_OFF;
    else if (ext) return MODE_EXT;
    else         return MODE_LEGACY;
  endfunction

  function automatic logic [DATA_W-1:0] legal_mask(input int pa_w);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++)
      m[i] = (i == BSP_BIT) || (i == EXT_BIT) || (i == EN_BIT) ||
             ((i >= BASE_LSB) && (i < pa_w));
    return m;
  endfunction
endpackage

// File: rtl/lic_write_check.sv
module lic_write_check
  import lic_pkg::*;
#(
  parameter int PA_W   = 36,
  parameter bit EXT_OK = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  lic_mode_e         cur_mode,
  input  logic [DATA_W-1:0] wdata,
  output logic              illegal
);
  localparam logic [DATA_W-1:0] LEGAL = legal_mask(PA_W);

  logic      rsv_hit, bad_combo, bad_move, ext_block;
  logic      new_en, new_ext;
  lic_mode_e new_mode;

  assign new_en    = wdata[EN_BIT];
  assign new_ext   = wdata[EXT_BIT];
  assign new_mode  = mode_of(new_en, new_ext);
  assign rsv_hit   = |(wdata & ~LEGAL);
  assign bad_combo = new_ext & ~new_en;

  always_comb begin
    bad_move = 1'b0;
    if (cur_mode == MODE_EXT && new_mode == MODE_LEGACY) bad_move = 1'b1;
    if (cur_mode == MODE_OFF && new_mode == MODE_EXT)    bad_move = 1'b1;
  end

  generate
    if (EXT_OK) begin : g_ext_allowed
      assign ext_block = 1'b0;
    end else begin : g_ext_absent
      assign ext_block = new_ext;
    end
  endgenerate

  assign illegal = rsv_hit | bad_combo | bad_move | ext_block;

  assert_bit0_faults_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wdata[0] |-> illegal);
  assert_high_bit_faults_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wdata[PA_W] |-> illegal);
  assert_invalid_combo_faults_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wdata[EXT_BIT] && !wdata[EN_BIT]) |-> illegal);
endmodule

// File: rtl/lic_window_decode.sv
module lic_window_decode
  import lic_pkg::*;
#(
  parameter int PA_W = 36
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  lic_mode_e              mode,
  input  logic [PA_W-1:BASE_LSB] base,
  input  logic [PA_W-1:0]        addr,
  output logic                   sel,
  output logic                   float_rd
);
  logic page_hit;

  assign page_hit = (addr[PA_W-1:BASE_LSB] == base);
  assign sel      = page_hit & (mode == MODE_LEGACY);
  assign float_rd = page_hit & (mode != MODE_LEGACY);

  assert_window_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel, float_rd}));
endmodule

// File: rtl/lic_base_reg.sv
module lic_base_reg
  import lic_pkg::*;
#(
  parameter int          PA_W     = 36,
  parameter bit          EXT_OK   = 1'b1,
  parameter bit          BSP_INIT = 1'b1,
  parameter logic [63:0] RST_BASE = 64'h0000_0000_FEE0_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_valid,
  output logic            wr_ready,
  input  logic [63:0]     wr_data,
  output logic            fault_o,
  output logic [63:0]     reg_o,
  output logic [1:0]      mode_o,
  output logic            feature_o,
  input  logic [PA_W-1:0] win_addr,
  output logic            win_sel_o,
  output logic            win_float_o
);
  localparam logic [DATA_W-1:0] LEGAL = legal_mask(PA_W);

  logic                   en_q, ext_q, bsp_q, fault_q;
  logic [PA_W-1:BASE_LSB] base_q;
  logic                   wr_fire, illegal;
  lic_mode_e              mode;

  assign wr_ready = 1'b1;
  assign wr_fire  = wr_valid & wr_ready;
  assign mode     = mode_of(en_q, ext_q);

  lic_write_check #(.PA_W(PA_W), .EXT_OK(EXT_OK)) u_check (
    .clk      (clk),
    .rst_n    (rst_n),
    .cur_mode (mode),
    .wdata    (wr_data),
    .illegal  (illegal)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b1;
      ext_q   <= 1'b0;
      bsp_q   <= BSP_INIT;
      base_q  <= RST_BASE[PA_W-1:BASE_LSB];
      fault_q <= 1'b0;
    end else begin
      fault_q <= wr_fire & illegal;
      if (wr_fire && !illegal) begin
        en_q   <= wr_data[EN_BIT];
        ext_q  <= wr_data[EXT_BIT];
        bsp_q  <= wr_data[BSP_BIT];
        base_q <= wr_data[PA_W-1:BASE_LSB];
      end
    end
  end

  always_comb begin
    reg_o                  = '0;
    reg_o[EN_BIT]          = en_q;
    reg_o[EXT_BIT]         = ext_q;
    reg_o[BSP_BIT]         = bsp_q;
    reg_o[PA_W-1:BASE_LSB] = base_q;
  end

  assign fault_o   = fault_q;
  assign mode_o    = mode;
  assign feature_o = (mode != MODE_OFF);

  lic_window_decode #(.PA_W(PA_W)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .base     (base_q),
    .addr     (win_addr),
    .sel      (win_sel_o),
    .float_rd (win_float_o)
  );

  assert_hold_on_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> $stable(reg_o));
  assert_fault_needs_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> $past(wr_valid));
  assert_no_ext_to_legacy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == MODE_LEGACY) |-> ($past(mode_o) != MODE_EXT));
  assert_no_off_to_ext_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == MODE_EXT) |-> ($past(mode_o) != MODE_OFF));
  assert_reserved_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_o & ~LEGAL) == '0);
endmodule

// File: tb/lic_base_reg_test.sv
module lic_base_reg_test;
  localparam int PA_W = 36;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wr_valid = 1'b0;
  logic            wr_ready;
  logic [63:0]     wr_data = '0;
  logic            fault_o;
  logic [63:0]     reg_o;
  logic [1:0]      mode_o;
  logic            feature_o;
  logic [PA_W-1:0] win_addr = '0;
  logic            win_sel_o, win_float_o;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  lic_base_reg #(.PA_W(PA_W)) uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .fault_o(fault_o), .reg_o(reg_o), .mode_o(mode_o),
    .feature_o(feature_o), .win_addr(win_addr), .win_sel_o(win_sel_o),
    .win_float_o(win_float_o)
  );

  typedef struct {
    logic [63:0] val;
    logic        flt;
    logic [1:0]  md;
    string       req;
  } exp_t;

  exp_t        sb[$];
  logic [63:0] model = 64'hFEE0_0900;
  logic        pend = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] mode_ref(input logic [63:0] v);
    if (!v[11]) return 2'b00;
    return v[10] ? 2'b10 : 2'b01;
  endfunction

  function automatic logic bad_ref(input logic [63:0] cur, input logic [63:0] d);
    logic [63:0] legal = '0;
    legal[8] = 1'b1; legal[10] = 1'b1; legal[11] = 1'b1;
    for (int i = 12; i < PA_W; i++) legal[i] = 1'b1;
    if ((d & ~legal) != 0) return 1'b1;
    if (d[10] && !d[11]) return 1'b1;
    if (mode_ref(cur) == 2'b10 && mode_ref(d) == 2'b01) return 1'b1;
    if (mode_ref(cur) == 2'b00 && mode_ref(d) == 2'b10) return 1'b1;
    return 1'b0;
  endfunction

  task automatic wr(input logic [63:0] d, input string req);
    exp_t e;
    logic b;
    @(negedge clk);
    b = bad_ref(model, d);
    if (!b) model = d;
    e.val = model; e.flt = b; e.md = mode_ref(model); e.req = req;
    sb.push_back(e);
    wr_valid = 1'b1;
    wr_data  = d;
  endtask

  task automatic idle();
    @(negedge clk);
    wr_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic probe(input logic [PA_W-1:0] a, input logic s, input logic f, input string req);
    @(negedge clk);
    win_addr = a;
    #1;
    chk(win_sel_o === s, req, {63'b0, win_sel_o}, {63'b0, s});
    chk(win_float_o === f, req, {63'b0, win_float_o}, {63'b0, f});
  endtask

  always @(posedge clk) pend <= wr_valid && wr_ready && rst_n;

  always @(negedge clk) begin
    if (pend) begin
      if (sb.size() == 0) chk(1'b0, "scoreboard", 64'd0, 64'd1);
      else begin
        exp_t e;
        e = sb.pop_front();
        chk(reg_o === e.val, e.req, reg_o, e.val);
        chk(fault_o === e.flt, e.req, {63'b0, fault_o}, {63'b0, e.flt});
        chk(mode_o === e.md, e.req, {62'b0, mode_o}, {62'b0, e.md});
        chk(feature_o === (e.md != 2'b00), "R2 feature", {63'b0, feature_o}, {63'b0, e.md != 2'b00});
      end
    end else if (rst_n) begin
      chk(fault_o === 1'b0, "R8 no fault without write", {63'b0, fault_o}, 64'd0);
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 5000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<5000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(reg_o === 64'hFEE0_0900, "R1 reset value", reg_o, 64'hFEE0_0900);
    chk(mode_o === 2'b01, "R1 reset mode", {62'b0, mode_o}, 64'd1);
    chk(feature_o === 1'b1, "R1 feature", {63'b0, feature_o}, 64'd1);
    chk(fault_o === 1'b0, "R1 no fault", {63'b0, fault_o}, 64'd0);
    chk(wr_ready === 1'b1, "R12 ready", {63'b0, wr_ready}, 64'd1);
    probe(36'hFEE00030, 1'b1, 1'b0, "R10 default window");

    wr(64'hFEE0_0800, "R11 legacy rewrite clears bsp");
    wr(64'hFEE0_0C00, "R11 legacy to extended");
    wr(64'hFEE0_0800, "R4 extended to legacy faults");
    wr(64'hFEE0_0400, "R3 ext without enable faults");
    wr(64'hFEE0_0000, "R4 extended to off accepted");
    idle();
    probe(36'hFEE00030, 1'b0, 1'b1, "R9 off window floats");
    wr(64'hFEE0_0C00, "R5 off to extended faults");
    wr(64'hFEE0_0400, "R3 ext without enable faults from off");
    wr(64'hFED4_0900, "R5 off to legacy relocated");
    idle();
    probe(36'hFED40030, 1'b1, 1'b0, "R10 new base selected");
    probe(36'hFEE00030, 1'b0, 1'b0, "R10 old base ignored");
    wr(64'hFED4_0901, "R6 bit0 faults");
    wr(64'hFED4_0B00, "R6 bit9 faults");
    wr(64'hFED4_0980, "R6 bit7 faults");
    wr(64'h0000_0010_FED4_0900, "R7 bit PA_W faults");
    wr(64'h8000_0000_FEE0_0900, "R7 bit63 faults");
    wr(64'h0000_0008_FED4_0900, "R7 bit below PA_W accepted");
    wr(64'hFEE0_0900, "R11 base back");
    wr(64'hFEE0_0D00, "R12 back-to-back first");
    wr(64'hFEE0_0900, "R12 back-to-back second faults");
    wr(64'hFEE0_0100, "R12 back-to-back third to off");
    idle();
    probe(36'hFEE00FFC, 1'b0, 1'b1, "R9 off page top floats");
    chk(feature_o === 1'b0, "R9 feature off", {63'b0, feature_o}, 64'd0);
    idle();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule